// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

This block is a cycle-accurate, synthesizable model of a flow-through synchronous burst SRAM holding 2^AW words of 18 bits. Each word is two 9-bit lanes; the top bit of each lane is that lane's parity bit, and it is written together with the lane's data. Addresses, strobes, chip selects, write controls and write data are all taken on the rising clock edge. Read data for the address registered at an edge appears after that same edge, with no extra pipeline stage, and is gated by an asynchronous output enable.

A burst opens with either of two active-low address strobes: a processor strobe, which always opens a read, or a controller strobe, which opens a read or a write according to the write controls. Each later cycle with the active-low advance input low moves a 2-bit burst counter to the next of four addresses. A cycle with no strobe and no advance holds the current address. The order of the four beats is set by a mode pin. High selects interleaved order, which is the level an unconnected pin settles to through its internal pull-up. Low selects linear order.

The block is a pin-level memory model with no streaming interface, so it has no valid/ready handshake and no back-pressure. The tri-state data bus is modelled as a separate write-data input, a read-data output and a drive flag. The read-data output reads as zero whenever the drive flag is low.

Top module: `sync_burst_sram`

## Requirements
- R1: The device is selected only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. An honoured strobe taken while not selected ends any burst, and `dq_oe` is 0 after that edge. An advance with no open burst does nothing.
- R2: A processor-strobe cycle (`cpu_strobe_n`=0) is always a read and ignores `wr_all_n` and `wr_lane_n`. When `sel_a_n`=1 the processor strobe is ignored completely, and the open burst state and output are kept.
- R3: A controller-strobe cycle (`ctl_strobe_n`=0) with the device selected loads `addr`. It is a write if `wr_all_n`=0 or any `wr_lane_n` bit is 0, and a read otherwise. When both strobes are low and the processor strobe is honoured, the processor strobe wins and the cycle is a read.
- R4: Lane 0 is `wdata`/`dq` bits [8:0] with parity at bit 8, and lane 1 is bits [17:9] with parity at bit 17. `wr_lane_n[0]`=0 writes lane 0 and `wr_lane_n[1]`=0 writes lane 1. A lane that is not enabled keeps its stored value.
- R5: `wr_all_n`=0 writes both lanes whatever the value of `wr_lane_n`.
- R6: Flow-through read: after the edge that registers a read address, `dq` shows that word in the same cycle.
- R7: `dq_oe` is 1 only while `out_en_n`=0 and the current cycle is a read. The enable acts without waiting for a clock, and `dq` is all zeros whenever `dq_oe` is 0.
- R8: With `order_il`=1, beat n (n = 0..3) of a burst loaded at low address bits b uses low bits b XOR n. The fifth beat wraps back to b.
- R9: With `order_il`=0, beat n uses low bits (b + n) mod 4. In both orders the upper address bits never change inside a burst.
- R10: Advance cycles read or write the next burst address according to the write controls. A cycle with no strobe and `advance_n`=1 keeps the current address.
- R11: After a write cycle, `dq_oe` stays 0 through hold cycles until a strobe or an advance starts a read.
- R12: Reset (`rst_n`=0, asynchronous) closes any burst and clears `dq_oe`. It does not clear the stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Word address taken on a strobe |
| cpu_strobe_n | input | 1 | Processor address strobe, active low, read only |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Chip select, active low; also gates the processor strobe |
| sel_b_n | input | 1 | Chip select, active low |
| sel_c | input | 1 | Chip select, active high |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| wr_lane_n | input | LANES | Per-lane write enables, active low |
| order_il | input | 1 | Burst order: 1 interleaved, 0 linear |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | LANES*LANE_W | Write data taken on the clock edge |
| dq | output | LANES*LANE_W | Read data, zero when not driven |
| dq_oe | output | 1 | High while the model drives the data bus |

## Verification
The properties assume that `order_il` is held steady through a burst. They also assume that no strobe and advance mix that the requirements leave undefined reaches the block. The stepping and holding checks accept a cycle in which the mode pin changes. The stimulus sets the mode only on strobe cycles and reads back only words it has written before, so every expected value follows from earlier vectors.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  localparam int LANE_W_DEF = 9;
  localparam int LANES_DEF  = 2;
  localparam int AW_DEF     = 8;

  typedef enum logic [2:0] {
    CYC_NONE,
    CYC_LOAD,
    CYC_STEP,
    CYC_HOLD,
    CYC_DROP
  } cyc_e;
endpackage

// File: rtl/ssb_burst_ctr.sv
module ssb_burst_ctr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          interleave,
  input  logic [AW-1:0] load_addr,
  output logic [AW-1:0] cyc_addr,
  output logic [AW-1:0] cur_addr
);
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic [1:0]    cnt_nx;
  logic [AW-1:0] step_addr;

  function automatic logic [1:0] beat_lo(input logic [1:0] lo, input logic [1:0] n,
                                         input logic il);
    return il ? (lo ^ n) : (lo + n);
  endfunction

  assign cnt_nx    = cnt_q + 2'd1;
  assign cur_addr  = {base_q[AW-1:2], beat_lo(base_q[1:0], cnt_q, interleave)};
  assign step_addr = {base_q[AW-1:2], beat_lo(base_q[1:0], cnt_nx, interleave)};

  always_comb begin
    if (load)      cyc_addr = load_addr;
    else if (step) cyc_addr = step_addr;
    else           cyc_addr = cur_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= load_addr;
      cnt_q  <= '0;
    end else if (step) begin
      cnt_q  <= cnt_nx;
    end
  end
endmodule

// File: rtl/ssb_array.sv
module ssb_array #(
  parameter int AW     = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        lane_we,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[l]) cells[waddr] <= wdata[l*LANE_W +: LANE_W];
    end

    assign rdata[l*LANE_W +: LANE_W] = cells[raddr];
  end
endmodule

// File: rtl/ssb_cycle_dec.sv
module ssb_cycle_dec #(
  parameter int LANES = 2
) (
  input  logic             cpu_strobe_n,
  input  logic             ctl_strobe_n,
  input  logic             advance_n,
  input  logic             sel_a_n,
  input  logic             sel_b_n,
  input  logic             sel_c,
  input  logic             wr_all_n,
  input  logic [LANES-1:0] wr_lane_n,
  input  logic             burst_live,
  output ssb_pkg::cyc_e    kind,
  output logic             is_wr,
  output logic [LANES-1:0] lane_we
);
  import ssb_pkg::*;

  logic sel_ok, cpu_go, ctl_go, wr_req;

  assign sel_ok = !sel_a_n && !sel_b_n && sel_c;
  assign cpu_go = !cpu_strobe_n && !sel_a_n;
  assign ctl_go = !ctl_strobe_n && !cpu_go;
  assign wr_req = !wr_all_n || !(&wr_lane_n);

  always_comb begin
    kind  = CYC_NONE;
    is_wr = 1'b0;
    if (cpu_go) begin
      kind = sel_ok ? CYC_LOAD : CYC_DROP;
    end else if (ctl_go) begin
      kind  = sel_ok ? CYC_LOAD : CYC_DROP;
      is_wr = sel_ok && wr_req;
    end else if (burst_live && !advance_n) begin
      kind  = CYC_STEP;
      is_wr = wr_req;
    end else if (burst_live) begin
      kind  = CYC_HOLD;
      is_wr = wr_req;
    end
  end

  assign lane_we = !is_wr ? '0 : (!wr_all_n ? '1 : ~wr_lane_n);
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int AW     = ssb_pkg::AW_DEF,
  parameter int LANE_W = ssb_pkg::LANE_W_DEF,
  parameter int LANES  = ssb_pkg::LANES_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           addr,
  input  logic                    cpu_strobe_n,
  input  logic                    ctl_strobe_n,
  input  logic                    advance_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b_n,
  input  logic                    sel_c,
  input  logic                    wr_all_n,
  input  logic [LANES-1:0]        wr_lane_n,
  input  logic                    order_il,
  input  logic                    out_en_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] dq,
  output logic                    dq_oe
);
  import ssb_pkg::*;

  localparam int WORD_W = LANES * LANE_W;

  cyc_e             kind;
  logic             is_wr;
  logic [LANES-1:0] lane_we;
  logic             burst_live;
  logic             drive_q;
  logic             drive_nx;
  logic [AW-1:0]    cyc_addr;
  logic [AW-1:0]    rd_addr;
  logic [WORD_W-1:0] rd_word;

  ssb_cycle_dec #(.LANES(LANES)) u_dec (
    .cpu_strobe_n (cpu_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .advance_n    (advance_n),
    .sel_a_n      (sel_a_n),
    .sel_b_n      (sel_b_n),
    .sel_c        (sel_c),
    .wr_all_n     (wr_all_n),
    .wr_lane_n    (wr_lane_n),
    .burst_live   (burst_live),
    .kind         (kind),
    .is_wr        (is_wr),
    .lane_we      (lane_we)
  );

  ssb_burst_ctr #(.AW(AW)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (kind == CYC_LOAD),
    .step       (kind == CYC_STEP),
    .interleave (order_il),
    .load_addr  (addr),
    .cyc_addr   (cyc_addr),
    .cur_addr   (rd_addr)
  );

  ssb_array #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES)) u_arr (
    .clk     (clk),
    .lane_we (lane_we),
    .waddr   (cyc_addr),
    .wdata   (wdata),
    .raddr   (rd_addr),
    .rdata   (rd_word)
  );

  always_comb begin
    unique case (kind)
      CYC_LOAD, CYC_STEP: drive_nx = !is_wr;
      CYC_HOLD:           drive_nx = is_wr ? 1'b0 : drive_q;
      CYC_DROP:           drive_nx = 1'b0;
      default:            drive_nx = drive_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_live <= 1'b0;
      drive_q    <= 1'b0;
    end else begin
      drive_q <= drive_nx;
      if (kind == CYC_LOAD)      burst_live <= 1'b1;
      else if (kind == CYC_DROP) burst_live <= 1'b0;
    end
  end

  assign dq_oe = drive_q && !out_en_n;
  assign dq    = dq_oe ? rd_word : '0;
endmodule

// File: rtl/ssb_checker.sv
module ssb_checker #(
  parameter int AW    = 8,
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_strobe_n,
  input logic             ctl_strobe_n,
  input logic             advance_n,
  input logic             sel_a_n,
  input logic             sel_b_n,
  input logic             sel_c,
  input logic             wr_all_n,
  input logic [LANES-1:0] wr_lane_n,
  input logic             order_il,
  input logic             out_en_n,
  input logic             dq_oe,
  input logic             burst_live,
  input logic [AW-1:0]    rd_addr
);
  logic sel_ok, no_strobe, wr_req;
  assign sel_ok    = !sel_a_n && !sel_b_n && sel_c;
  assign no_strobe = cpu_strobe_n && ctl_strobe_n;
  assign wr_req    = !wr_all_n || (wr_lane_n != '1);

  AST_DESELECT_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_strobe_n && !ctl_strobe_n && !sel_ok) |=> !dq_oe); // R1

  AST_CPU_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_strobe_n && sel_ok) |=> (dq_oe == !out_en_n)); // R2

  AST_WRITE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_strobe_n && !ctl_strobe_n && sel_ok && wr_req) |=> !dq_oe); // R11

  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !dq_oe); // R7

  AST_IL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_live && no_strobe && !advance_n && order_il)
      |=> (!order_il || (rd_addr[0] != $past(rd_addr[0])))); // R8

  AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_live && no_strobe && !advance_n && !order_il)
      |=> (order_il || (rd_addr[1:0] == $past(rd_addr[1:0]) + 2'd1))); // R9

  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_live && no_strobe && !advance_n)
      |=> (rd_addr[AW-1:2] == $past(rd_addr[AW-1:2]))); // R9

  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_live && no_strobe && advance_n)
      |=> ($stable(rd_addr) || (order_il != $past(order_il)))); // R10
endmodule

bind sync_burst_sram ssb_checker #(.AW(AW), .LANES(LANES)) u_ssb_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_strobe_n (cpu_strobe_n),
  .ctl_strobe_n (ctl_strobe_n),
  .advance_n    (advance_n),
  .sel_a_n      (sel_a_n),
  .sel_b_n      (sel_b_n),
  .sel_c        (sel_c),
  .wr_all_n     (wr_all_n),
  .wr_lane_n    (wr_lane_n),
  .order_il     (order_il),
  .out_en_n     (out_en_n),
  .dq_oe        (dq_oe),
  .burst_live   (burst_live),
  .rd_addr      (rd_addr)
);

// File: tb/sync_burst_sram_bench.sv
module sync_burst_sram_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        cpu_strobe_n = 1'b1, ctl_strobe_n = 1'b1, advance_n = 1'b1;
  logic        sel_a_n = 1'b0, sel_b_n = 1'b0, sel_c = 1'b1;
  logic        wr_all_n = 1'b1;
  logic [1:0]  wr_lane_n = 2'b11;
  logic        order_il = 1'b1, out_en_n = 1'b0;
  logic [17:0] wdata = '0;
  logic [17:0] dq;
  logic        dq_oe;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sync_burst_sram u_sync_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n), .advance_n(advance_n),
    .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
    .wr_all_n(wr_all_n), .wr_lane_n(wr_lane_n), .order_il(order_il),
    .out_en_n(out_en_n), .wdata(wdata), .dq(dq), .dq_oe(dq_oe)
  );

  // strobes {cpu,ctl,adv}_n, selects {a_n,b_n,c}, wr_all_n, wr_lane_n, order_il,
  // out_en_n, addr, wdata, expected dq_oe, expected dq, requirement number
  typedef struct packed {
    logic [2:0]  strb;
    logic [2:0]  sel;
    logic        gwn;
    logic [1:0]  lwn;
    logic        il;
    logic        oen;
    logic [7:0]  ad;
    logic [17:0] wd;
    logic        xoe;
    logic [17:0] xq;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VT [NV] = '{
    {3'b101, 3'b001, 1'b0, 2'b11, 1'b1, 1'b0, 8'h10, 18'h12345, 1'b0, 18'h00000, 4'd3},  // R3 write 10
    {3'b110, 3'b001, 1'b1, 2'b00, 1'b1, 1'b0, 8'h00, 18'h21111, 1'b0, 18'h00000, 4'd10}, // R10 write 11
    {3'b110, 3'b001, 1'b1, 2'b00, 1'b1, 1'b0, 8'h00, 18'h02222, 1'b0, 18'h00000, 4'd10}, // R10 write 12
    {3'b110, 3'b001, 1'b1, 2'b00, 1'b1, 1'b0, 8'h00, 18'h33333, 1'b0, 18'h00000, 4'd10}, // R10 write 13
    {3'b011, 3'b001, 1'b0, 2'b00, 1'b1, 1'b0, 8'h12, 18'h00BAD, 1'b1, 18'h02222, 4'd2},  // R2 R6 cpu read 12
    {3'b110, 3'b001, 1'b1, 2'b11, 1'b1, 1'b0, 8'h00, 18'h00000, 1'b1, 18'h33333, 4'd8},  // R8 beat 13
    {3'b110, 3'b001, 1'b1, 2'b11, 1'b1, 1'b0, 8'h00, 18'h00000, 1'b1, 18'h12345, 4'd8},  // R8 beat 10
    {3'b110, 3'b001, 1'b1, 2'b11, 1'b1, 1'b0, 8'h00, 18'h00000, 1'b1, 18'h21111, 4'd8},  // R8 beat 11
    {3'b110, 3'b001, 1'b1, 2'b11, 1'b1, 1'b0, 8'h00, 18'h00000, 1'b1, 18'h02222, 4'd8},  // R8 wrap 12
    {3'b011, 3'b001, 1'b1, 2'b11, 1'b0, 1'b0, 8'h13, 18'h00000, 1'b1, 18'h33333, 4'd6},  // R6 read 13
    {3'b110, 3'b001, 1'b1, 2'b11, 1'b0, 1'b0, 8'h00, 18'h00000, 1'b1, 18'h12345, 4'd9},  // R9 wrap 10
    {3'b110, 3'b001, 1'b1, 2'b11, 1'b0, 1'b0, 8'h00, 18'h00000, 1'b1, 18'h21111, 4'd9},  // R9 11
    {3'b110, 3'b001, 1'b1, 2'b11, 1'b0, 1'b0, 8'h00, 18'h00000, 1'b1, 18'h02222, 4'd9},  // R9 12
    {3'b111, 3'b001, 1'b1, 2'b11, 1'b0, 1'b0, 8'h00, 18'h00000, 1'b1, 18'h02222, 4'd10}, // R10 hold
    {3'b111, 3'b001, 1'b1, 2'b11, 1'b0, 1'b1, 8'h00, 18'h00000, 1'b0, 18'h00000, 4'd7},  // R7 oe off
    {3'b101, 3'b001, 1'b1, 2'b10, 1'b1, 1'b0, 8'h10, 18'h3FE55, 1'b0, 18'h00000, 4'd4},  // R4 lane 0
    {3'b111, 3'b001, 1'b1, 2'b11, 1'b1, 1'b0, 8'h00, 18'h00000, 1'b0, 18'h00000, 4'd11}, // R11 stays dark
    {3'b101, 3'b001, 1'b1, 2'b01, 1'b1, 1'b0, 8'h11, 18'h3C1FF, 1'b0, 18'h00000, 4'd4},  // R4 lane 1
    {3'b101, 3'b001, 1'b1, 2'b11, 1'b1, 1'b0, 8'h10, 18'h00000, 1'b1, 18'h12255, 4'd4},  // R4 check 10
    {3'b101, 3'b001, 1'b1, 2'b11, 1'b1, 1'b0, 8'h11, 18'h00000, 1'b1, 18'h3C111, 4'd4},  // R4 check 11
    {3'b101, 3'b001, 1'b0, 2'b10, 1'b1, 1'b0, 8'h12, 18'h05A5A, 1'b0, 18'h00000, 4'd5},  // R5 global
    {3'b011, 3'b001, 1'b1, 2'b11, 1'b1, 1'b0, 8'h12, 18'h00000, 1'b1, 18'h05A5A, 4'd5},  // R5 check
    {3'b011, 3'b101, 1'b1, 2'b11, 1'b1, 1'b0, 8'h10, 18'h00000, 1'b1, 18'h05A5A, 4'd2},  // R2 ignored
    {3'b101, 3'b000, 1'b1, 2'b11, 1'b1, 1'b0, 8'h10, 18'h00000, 1'b0, 18'h00000, 4'd1},  // R1 deselect
    {3'b110, 3'b001, 1'b1, 2'b11, 1'b1, 1'b0, 8'h00, 18'h00000, 1'b0, 18'h00000, 4'd1},  // R1 no burst
    {3'b011, 3'b001, 1'b1, 2'b11, 1'b1, 1'b0, 8'h13, 18'h00000, 1'b1, 18'h33333, 4'd6},  // R6 read 13
    {3'b011, 3'b011, 1'b1, 2'b11, 1'b1, 1'b0, 8'h10, 18'h00000, 1'b0, 18'h00000, 4'd1},  // R1 sel_b off
    {3'b001, 3'b001, 1'b0, 2'b11, 1'b1, 1'b0, 8'h10, 18'h00001, 1'b1, 18'h12255, 4'd3},  // R3 cpu wins
    {3'b101, 3'b001, 1'b1, 2'b11, 1'b1, 1'b0, 8'h10, 18'h00000, 1'b1, 18'h12255, 4'd3},  // R3 not written
    {3'b101, 3'b001, 1'b0, 2'b11, 1'b1, 1'b0, 8'h13, 18'h10F0F, 1'b0, 18'h00000, 4'd11}, // R11 write 13
    {3'b110, 3'b001, 1'b1, 2'b11, 1'b1, 1'b0, 8'h00, 18'h00000, 1'b1, 18'h05A5A, 4'd11}  // R11 advance
  };

  task automatic check(input int rq, input logic act_oe, input logic [17:0] act_q,
                       input logic exp_oe, input logic [17:0] exp_q);
    checks++;
    if (act_oe !== exp_oe || act_q !== exp_q) begin
      failures++;
      $display("FAIL R%0d: dq_oe=%b dq=%h expected dq_oe=%b dq=%h",
               rq, act_oe, act_q, exp_oe, exp_q);
    end
  endtask

  task automatic idle_inputs();
    {cpu_strobe_n, ctl_strobe_n, advance_n} = 3'b111;
    {sel_a_n, sel_b_n, sel_c} = 3'b001;
    wr_all_n = 1'b1; wr_lane_n = 2'b11; out_en_n = 1'b0;
  endtask

  initial begin
    idle_inputs();
    repeat (3) @(posedge clk);
    #5 check(12, dq_oe, dq, 1'b0, 18'h0); // R12 reset state
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {cpu_strobe_n, ctl_strobe_n, advance_n} = VT[i].strb;
      {sel_a_n, sel_b_n, sel_c} = VT[i].sel;
      wr_all_n = VT[i].gwn; wr_lane_n = VT[i].lwn;
      order_il = VT[i].il;  out_en_n = VT[i].oen;
      addr = VT[i].ad;      wdata = VT[i].wd;
      @(posedge clk);
      #5 check(int'(VT[i].rq), dq_oe, dq, VT[i].xoe, VT[i].xq);
    end

    // R7: output enable acts without a clock edge
    @(negedge clk) idle_inputs();
    #1 check(7, dq_oe, dq, 1'b1, 18'h05A5A);
    out_en_n = 1'b1;
    #1 check(7, dq_oe, dq, 1'b0, 18'h0);
    out_en_n = 1'b0;

    // R12: reset mid-burst clears drive, advance then finds no burst
    @(negedge clk) rst_n = 1'b0;
    #1 check(12, dq_oe, dq, 1'b0, 18'h0);
    @(negedge clk) rst_n = 1'b1; advance_n = 1'b0;
    @(posedge clk);
    #5 check(12, dq_oe, dq, 1'b0, 18'h0);
    // R12: stored words survive reset
    @(negedge clk) advance_n = 1'b1; cpu_strobe_n = 1'b0; addr = 8'h12;
    @(posedge clk);
    #5 check(12, dq_oe, dq, 1'b1, 18'h05A5A);
    @(negedge clk) idle_inputs();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule